// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it compares the destination register of the instruction in execute against the two source register fields of the instruction in decode. When the instruction in execute is a load, its data is not ready until the end of the memory stage. Forwarding alone therefore cannot supply that data to the very next instruction. In that case the controller freezes the program counter and the fetch/decode register for one cycle. It also clears the control bundle that enters the decode/execute register, which sends a no-operation down the pipe.

The stall decision is purely combinational. One cycle later, the bubble sits in the decode/execute register and its memory-read bit is zero, so the stall drops without any state in this block. The dependent instruction then reaches execute two stages behind the load. At that point the load value can be forwarded from the memory/writeback register. Without forwarding, the same dependency would need a two-cycle stall; this block is built for a pipeline that has forwarding.

Top module: `load_use_stall_ctl`

## Requirements
- R1: A stall is raised in the same cycle when the execute-stage memory-read flag is 1, the execute-stage destination is nonzero, and that destination equals the decode-stage first source field.
- R2: A stall is raised on the same conditions when the destination equals the decode-stage second source field.
- R3: No stall is raised while the execute-stage memory-read flag is 0, whatever the register fields hold.
- R4: No stall is raised when the execute-stage destination is register 0.
- R5: While stalling, both the PC write enable and the fetch/decode write enable are 0. At all other times both are 1.
- R6: While stalling, every bit of the outgoing control bundle is 0. At all other times it equals the incoming bundle. The memory-read flag is bit 3 of the bundle.
- R7: Once the bubble is fed back into the execute stage, the stall lasts exactly one cycle. When the dependent instruction is in execute, the load is in the memory/writeback register and a bubble is in the execute/memory register.
- R8: A consumer two instructions after a load is not stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used only by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| ex_mem_read_i | input | 1 | Memory-read flag of the instruction in execute |
| ex_dst_i | input | 5 | Load destination field of the instruction in execute |
| dec_src_a_i | input | 5 | First source field of the instruction in decode |
| dec_src_b_i | input | 5 | Second source field of the instruction in decode |
| ctrl_i | input | 9 | Control bundle produced by the decoder |
| pc_we_o | output | 1 | Program counter write enable |
| dec_we_o | output | 1 | Fetch/decode register write enable |
| bubble_o | output | 1 | High when a no-operation is inserted |
| ctrl_o | output | 9 | Control bundle to load into the decode/execute register |

## Verification
The one-cycle property assumes the surrounding pipeline loads bit 3 of ctrl_o into ex_mem_read_i at each clock edge. The other properties also assume that the register fields advance only when dec_we_o is high. The bench meets this with a small pipeline model of its own: it latches ctrl_o and the decode fields into an execute register and refetches while the enables are low. Short instruction sequences then exercise back-to-back loads, zero destinations and distance-two consumers.

// File: rtl/lu_stall_pkg.sv
package lu_stall_pkg;
  localparam int NUM_SRC = 2;
  typedef enum int unsigned {
    SRC_A = 0,
    SRC_B = 1
  } src_sel_e;
endpackage

// File: rtl/lu_field_cmp.sv
module lu_field_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] lhs_i,
  input  logic [REG_W-1:0] rhs_i,
  output logic             eq_o
);
  assign eq_o = (lhs_i == rhs_i);
endmodule

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect
  import lu_stall_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             mem_read_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src_i [NUM_SRC],
  output logic             hit_o
);
  logic [NUM_SRC-1:0] match;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    lu_field_cmp #(.REG_W(REG_W)) u_cmp (
      .lhs_i(dst_i),
      .rhs_i(src_i[g]),
      .eq_o (match[g])
    );
  end

  // register 0 is never a real producer
  assign hit_o = mem_read_i && (dst_i != '0) && (|match);
endmodule

// File: rtl/lu_ctrl_gate.sv
module lu_ctrl_gate #(
  parameter int CTRL_W = 9
) (
  input  logic              kill_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  assign ctrl_o = kill_i ? '0 : ctrl_i;
endmodule

// File: rtl/load_use_stall_ctl.sv
module load_use_stall_ctl
  import lu_stall_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int CTRL_W      = 9,
  parameter int MEMREAD_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_mem_read_i,
  input  logic [REG_W-1:0]  ex_dst_i,
  input  logic [REG_W-1:0]  dec_src_a_i,
  input  logic [REG_W-1:0]  dec_src_b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              pc_we_o,
  output logic              dec_we_o,
  output logic              bubble_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [REG_W-1:0] srcs [NUM_SRC];
  logic             hazard;

  assign srcs[SRC_A] = dec_src_a_i;
  assign srcs[SRC_B] = dec_src_b_i;

  lu_hazard_detect #(.REG_W(REG_W)) u_detect (
    .mem_read_i(ex_mem_read_i),
    .dst_i     (ex_dst_i),
    .src_i     (srcs),
    .hit_o     (hazard)
  );

  lu_ctrl_gate #(.CTRL_W(CTRL_W)) u_gate (
    .kill_i(hazard),
    .ctrl_i(ctrl_i),
    .ctrl_o(ctrl_o)
  );

  assign bubble_o = hazard;
  assign pc_we_o  = !hazard;
  assign dec_we_o = !hazard;

  p_hold_front_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!pc_we_o && !dec_we_o));
  p_zero_ctrl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (ctrl_o == '0));
  p_pass_ctrl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_o |-> (ctrl_o == ctrl_i));
  p_no_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_mem_read_i |-> !bubble_o);
  p_zero_dst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0) |-> !bubble_o);
  // assumes ctrl_o[MEMREAD_BIT] feeds ex_mem_read_i next cycle
  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> !bubble_o);
  p_memrd_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> !ctrl_o[MEMREAD_BIT]);
endmodule

// File: tb/load_use_stall_ctl_tb_top.sv
module load_use_stall_ctl_tb_top;
  localparam int RW = 5;
  localparam int CW = 9;
  localparam int MR = 3;
  localparam logic [CW-1:0] C_LOAD = 9'b1_0100_1001;
  localparam logic [CW-1:0] C_ALU  = 9'b1_0010_0110;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [RW-1:0] ex_dst, dec_a, dec_b;
  logic          ex_mr;
  logic [CW-1:0] dec_ctrl, ctrl_out;
  logic          pc_we, dec_we, bubble;

  load_use_stall_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ex_mem_read_i(ex_mr), .ex_dst_i(ex_dst),
    .dec_src_a_i(dec_a), .dec_src_b_i(dec_b),
    .ctrl_i(dec_ctrl),
    .pc_we_o(pc_we), .dec_we_o(dec_we), .bubble_o(bubble), .ctrl_o(ctrl_out)
  );

  int checks = 0, errors = 0;
  bit running = 0;
  bit exp_q[$];
  string tag;
  bit fwd_chk;

  logic [RW-1:0] p_a [6], p_b [6];
  logic [CW-1:0] p_c [6];
  int p_len, pc, dec_idx, ex_idx, mem_idx, wb_idx;

  // bench-side pipeline registers around the controller
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 0; dec_a <= '0; dec_b <= '0; dec_ctrl <= '0; dec_idx <= -1;
      ex_mr <= 1'b0; ex_dst <= '0; ex_idx <= -1; mem_idx <= -1; wb_idx <= -1;
    end else begin
      if (dec_we) begin
        if (pc < p_len) begin
          dec_a <= p_a[pc]; dec_b <= p_b[pc]; dec_ctrl <= p_c[pc]; dec_idx <= pc;
        end else begin
          dec_a <= '0; dec_b <= '0; dec_ctrl <= '0; dec_idx <= -1;
        end
      end
      if (pc_we) pc <= pc + 1;
      ex_mr   <= ctrl_out[MR];
      ex_dst  <= dec_b;
      ex_idx  <= bubble ? -1 : dec_idx;
      mem_idx <= ex_idx;
      wb_idx  <= mem_idx;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(tag, bubble, e);
      chk("R5 pc_we", pc_we, !e);
      chk("R5 dec_we", dec_we, !e);
      chk("R6 ctrl", ctrl_out, e ? 0 : dec_ctrl);
      if (fwd_chk && ex_idx == 1) begin
        chk("R7 load in mem/wb", wb_idx, 0);
        chk("R7 bubble in ex/mem", mem_idx, -1);
      end
    end
  end

  task automatic run(input string t, input bit fc, input bit ex[]);
    tag = t; fwd_chk = fc;
    foreach (ex[i]) exp_q.push_back(ex[i]);
    rst_n = 0;
    @(posedge clk); #1 rst_n = 1; running = 1;
    wait (exp_q.size() == 0);
    @(posedge clk); #1 running = 0;
  endtask

  task automatic set_i(input int i, input int a, input int b, input logic [CW-1:0] c);
    p_a[i] = RW'(a); p_b[i] = RW'(b); p_c[i] = c;
  endtask

  initial begin
    fork
      begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    p_len = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("reset bubble R5", bubble, 0);
    chk("reset pc_we R5", pc_we, 1);
    chk("reset ctrl R6", ctrl_out, 0);

    // load r8; and r8,r5; or r6,r8; add r14,r0
    set_i(0, 29, 8, C_LOAD); set_i(1, 8, 5, C_ALU);
    set_i(2, 6, 8, C_ALU);   set_i(3, 14, 0, C_ALU); p_len = 4;
    run("R1 src_a", 1, '{0, 0, 1, 0, 0, 0});
    // load r8; add r3,r8
    set_i(0, 29, 8, C_LOAD); set_i(1, 3, 8, C_ALU); p_len = 2;
    run("R2 src_b", 0, '{0, 0, 1, 0});
    // load into r0; consumer of r0
    set_i(0, 29, 0, C_LOAD); set_i(1, 0, 0, C_ALU); p_len = 2;
    run("R4 dst zero", 0, '{0, 0, 0, 0});
    // non-load with rt=7, consumer of r7
    set_i(0, 1, 7, C_ALU); set_i(1, 7, 7, C_ALU); p_len = 2;
    run("R3 no load", 0, '{0, 0, 0, 0});
    // load r8; independent; consumer at distance two
    set_i(0, 29, 8, C_LOAD); set_i(1, 1, 2, C_ALU);
    set_i(2, 8, 8, C_ALU); p_len = 3;
    run("R8 distance two", 0, '{0, 0, 0, 0, 0});
    // load r4; load r5 using r4; consumer of r5
    set_i(0, 29, 4, C_LOAD); set_i(1, 4, 5, C_LOAD);
    set_i(2, 5, 9, C_ALU); p_len = 3;
    run("R7 back-to-back loads", 0, '{0, 0, 1, 0, 1, 0});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule